// File: doc/BRIEF.md
# Zero-Address Stack Evaluator

This block evaluates arithmetic written in postfix order. Each command arrives on a valid/ready input. A command either pushes an immediate value or pops the top entry to an output port. It can also be a binary operation. A binary operation names no operands: it takes the two topmost entries, combines them, and leaves the single result on top. A sequence produced from a postfix expression therefore runs with no address fields at all.

Storage is an internal register array. A stack pointer holds the index of the current top entry. The pointer starts one past the highest index and moves toward index zero as values are pushed. A popped value is held on the output until the consumer accepts it. A push onto a full stack sets a sticky overflow flag. A pop or operation with too few entries sets a sticky underflow flag. In both cases the stack is left untouched.

Top module: `stk_eval`

## Requirements
- R1: After reset the stack is empty, `cmd_ready` is 1, `out_valid` is 0, and both error flags are 0.
- R2: Pop returns entries in last-in, first-out order.
- R3: Add (code 2) replaces the two top entries with their sum modulo 2^16.
- R4: Subtract (code 3) replaces the two top entries with (second-from-top minus top) modulo 2^16, so pushing A, pushing B, then subtracting gives A-B.
- R5: Multiply (code 4) replaces the two top entries with the low 16 bits of their product.
- R6: After an accepted pop (code 1), `out_valid` is 1 from the next cycle on, with the popped value on `out_data`. Both stay stable, and `cmd_ready` stays 0, until a cycle with `out_ready` high. `out_valid` is 0 in the cycle after that.
- R7: A push (code 0) onto a stack holding 16 entries sets `err_ovf` and leaves the stack contents unchanged.
- R8: A pop on an empty stack, or a binary operation with fewer than two entries, sets `err_udf`. It produces no output and leaves the stack contents unchanged.
- R9: `err_ovf` and `err_udf` stay set until reset, and commands keep executing while they are set.
- R10: Command codes 5, 6 and 7 are accepted and have no effect on the stack, the output or the flags.
- R11: Every command other than a pop finishes in the cycle it is accepted, so `cmd_ready` stays 1 across a run of such commands.
- R12: The sequence push 3, push 4, multiply, push 5, push 6, multiply, add, pop outputs 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code: 0 push, 1 pop, 2 add, 3 subtract, 4 multiply, 5-7 no effect |
| cmd_imm | input | 16 | Value carried by a push |
| out_valid | output | 1 | Popped value present |
| out_ready | input | 1 | Consumer takes the popped value |
| out_data | output | 16 | Popped value |
| err_ovf | output | 1 | Sticky: push onto a full stack |
| err_udf | output | 1 | Sticky: too few entries for a pop or operation |

## Verification
The stack is visible only through pops, so any fault in the pointer or the array shows up at the first pop that reaches the damaged entry. Faults in the pointer's movement or in operand order also surface at the flags. A pointer that slips by one makes the next pop return a neighbouring value. It also moves the full or empty boundary by one push, so the error flags fire one command early or late. Swapped operands show at once on the first pop after a subtraction.

// File: rtl/stk_eval_pkg.sv
package stk_eval_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4
    } stk_op_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_MUL = 2'd2
    } alu_fn_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
    import stk_eval_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   res
);

    logic [2*W-1:0] prod;

    always_comb begin
        prod = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};
        case (fn)
            FN_ADD:  res = lhs + rhs;
            FN_SUB:  res = lhs - rhs;
            FN_MUL:  res = prod[W-1:0];
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] top_addr,
    output logic [W-1:0]  top_data,
    input  logic [AW-1:0] nxt_addr,
    output logic [W-1:0]  nxt_data
);

    logic [W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                cell_q[i] <= wdata;
            end
        end
    end

    assign top_data = cell_q[top_addr];
    assign nxt_data = cell_q[nxt_addr];

endmodule

// File: rtl/stk_eval.sv
module stk_eval
    import stk_eval_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              err_ovf,
    output logic              err_udf
);

    localparam int AW  = $clog2(DEPTH);
    localparam int SPW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [SPW-1:0]    sp;
        logic              out_vld;
        logic [DATA_W-1:0] out_dat;
        logic              ovf;
        logic              udf;
    } eval_st_t;

    eval_st_t st_d, st_q;

    logic              fire;
    logic              is_full, is_empty, has_two;
    logic [AW-1:0]     top_idx, nxt_idx, push_idx;
    logic [DATA_W-1:0] top_val, nxt_val, alu_res;
    logic              wr_en;
    logic [AW-1:0]     wr_idx;
    logic [DATA_W-1:0] wr_val;
    alu_fn_e           fn_sel;

    assign cmd_ready = !st_q.out_vld;
    assign fire      = cmd_valid && cmd_ready;
    assign is_full   = (st_q.sp == '0);
    assign is_empty  = (st_q.sp == SPW'(DEPTH));
    assign has_two   = (st_q.sp <= SPW'(DEPTH - 2));
    assign top_idx   = AW'(st_q.sp);
    assign nxt_idx   = AW'(st_q.sp + SPW'(1));
    assign push_idx  = AW'(st_q.sp - SPW'(1));

    stk_regs #(.W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .we       (wr_en),
        .waddr    (wr_idx),
        .wdata    (wr_val),
        .top_addr (top_idx),
        .top_data (top_val),
        .nxt_addr (nxt_idx),
        .nxt_data (nxt_val)
    );

    always_comb begin
        case (stk_op_e'(cmd_op))
            OP_SUB:  fn_sel = FN_SUB;
            OP_MUL:  fn_sel = FN_MUL;
            default: fn_sel = FN_ADD;
        endcase
    end

    // second-from-top is the left operand, top is the right operand
    stk_alu #(.W(DATA_W)) u_alu (
        .fn  (fn_sel),
        .lhs (nxt_val),
        .rhs (top_val),
        .res (alu_res)
    );

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = nxt_idx;
        wr_val = alu_res;
        if (st_q.out_vld && out_ready) begin
            st_d.out_vld = 1'b0;
        end
        if (fire) begin
            case (stk_op_e'(cmd_op))
                OP_PUSH: begin
                    if (is_full) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_idx  = push_idx;
                        wr_val  = cmd_imm;
                        st_d.sp = st_q.sp - SPW'(1);
                    end
                end
                OP_POP: begin
                    if (is_empty) begin
                        st_d.udf = 1'b1;
                    end else begin
                        st_d.out_vld = 1'b1;
                        st_d.out_dat = top_val;
                        st_d.sp      = st_q.sp + SPW'(1);
                    end
                end
                OP_ADD, OP_SUB, OP_MUL: begin
                    if (!has_two) begin
                        st_d.udf = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_idx  = nxt_idx;
                        wr_val  = alu_res;
                        st_d.sp = st_q.sp + SPW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp      <= SPW'(DEPTH);
            st_q.out_vld <= 1'b0;
            st_q.out_dat <= '0;
            st_q.ovf     <= 1'b0;
            st_q.udf     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_vld;
    assign out_data  = st_q.out_dat;
    assign err_ovf   = st_q.ovf;
    assign err_udf   = st_q.udf;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_NO_CMD_DURING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf); // R9
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_udf |=> err_udf); // R9
    AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 3'd0 && is_full) |=> (is_full && err_ovf)); // R7
    AST_EMPTY_POP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 3'd1 && is_empty) |=> (!out_valid && is_empty && err_udf)); // R8
    AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op >= 3'd5) |=> ($stable(st_q.sp) && $stable(err_ovf) && $stable(err_udf))); // R10

endmodule

// File: tb/test_stk_eval.sv
module test_stk_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_imm = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        err_ovf, err_udf;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stk_eval i_stk_eval (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_imm(cmd_imm), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .err_ovf(err_ovf), .err_udf(err_udf)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [15:0] imm);
        @(negedge clk);
        chk(cmd_ready === 1'b1, "R11 ready before command", 32'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [15:0] exp, input int hold, input string req);
        do_cmd(3'd1, '0);
        chk(out_valid === 1'b1, req, 32'(out_valid), 1);
        chk(out_data === exp, req, 32'(out_data), 32'(exp));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && out_data === exp, "R6 hold", 32'(out_data), 32'(exp));
            chk(cmd_ready === 1'b0, "R6 ready low", 32'(cmd_ready), 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid === 1'b0, "R6 release", 32'(out_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(cmd_ready === 1'b1, "R1 ready", 32'(cmd_ready), 1);
        chk(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(err_ovf === 1'b0 && err_udf === 1'b0, "R1 flags", {err_ovf, err_udf}, 0);
    endtask

    task automatic t_lifo();
        do_reset();
        do_cmd(3'd0, 16'd10); do_cmd(3'd0, 16'd20); do_cmd(3'd0, 16'd30);
        pop_expect(16'd30, 3, "R2 pop 30");
        pop_expect(16'd20, 0, "R2 pop 20");
        pop_expect(16'd10, 1, "R2 pop 10");
    endtask

    task automatic t_arith();
        do_reset();
        do_cmd(3'd0, 16'd7); do_cmd(3'd0, 16'd5); do_cmd(3'd3, '0);
        pop_expect(16'd2, 0, "R4 7-5");
        do_cmd(3'd0, 16'd5); do_cmd(3'd0, 16'd7); do_cmd(3'd3, '0);
        pop_expect(16'hFFFE, 0, "R4 5-7 wraps");
        do_cmd(3'd0, 16'hFFFF); do_cmd(3'd0, 16'd2); do_cmd(3'd2, '0);
        pop_expect(16'd1, 0, "R3 add wraps");
        do_cmd(3'd0, 16'd300); do_cmd(3'd0, 16'd300); do_cmd(3'd4, '0);
        pop_expect(16'd24464, 0, "R5 300*300 low bits");
        do_cmd(3'd0, 16'h1234); do_cmd(3'd0, 16'h0100); do_cmd(3'd4, '0);
        pop_expect(16'h3400, 0, "R5 shifted product");
        chk(err_ovf === 1'b0 && err_udf === 1'b0, "R3 no flags", {err_ovf, err_udf}, 0);
    endtask

    task automatic t_postfix();
        do_reset();
        do_cmd(3'd0, 16'd3); do_cmd(3'd0, 16'd4); do_cmd(3'd4, '0);
        do_cmd(3'd0, 16'd5); do_cmd(3'd0, 16'd6); do_cmd(3'd4, '0);
        do_cmd(3'd2, '0);
        pop_expect(16'd42, 0, "R12 postfix result");
    endtask

    task automatic t_reserved();
        do_reset();
        do_cmd(3'd0, 16'd9);
        do_cmd(3'd5, 16'd1); do_cmd(3'd6, 16'd2); do_cmd(3'd7, 16'd3);
        chk(out_valid === 1'b0, "R10 no output", 32'(out_valid), 0);
        chk(err_ovf === 1'b0 && err_udf === 1'b0, "R10 no flags", {err_ovf, err_udf}, 0);
        pop_expect(16'd9, 0, "R10 stack untouched");
    endtask

    task automatic t_underflow();
        do_reset();
        do_cmd(3'd2, '0);
        chk(err_udf === 1'b1, "R8 op on empty", 32'(err_udf), 1);
        chk(err_ovf === 1'b0, "R8 no overflow", 32'(err_ovf), 0);
        do_reset();
        do_cmd(3'd0, 16'd11); do_cmd(3'd4, '0);
        chk(err_udf === 1'b1, "R8 op with one entry", 32'(err_udf), 1);
        pop_expect(16'd11, 0, "R8 entry kept");
        do_cmd(3'd1, '0);
        chk(out_valid === 1'b0, "R8 empty pop quiet", 32'(out_valid), 0);
        chk(cmd_ready === 1'b1, "R8 ready after empty pop", 32'(cmd_ready), 1);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= 16; i++) do_cmd(3'd0, 16'(i));
        chk(err_ovf === 1'b0, "R7 full but no flag", 32'(err_ovf), 0);
        do_cmd(3'd0, 16'd99);
        chk(err_ovf === 1'b1, "R7 push on full", 32'(err_ovf), 1);
        for (int i = 16; i >= 1; i--) pop_expect(16'(i), 0, "R7 contents kept");
        do_cmd(3'd1, '0);
        chk(err_udf === 1'b1 && out_valid === 1'b0, "R8 pop after drain", {err_udf, out_valid}, 2'b10);
        chk(err_ovf === 1'b1, "R9 overflow sticky", 32'(err_ovf), 1);
        do_cmd(3'd0, 16'd8); do_cmd(3'd0, 16'd9); do_cmd(3'd2, '0);
        pop_expect(16'd17, 0, "R9 runs with flags set");
        chk(err_ovf === 1'b1 && err_udf === 1'b1, "R9 both sticky", {err_ovf, err_udf}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_lifo();
        t_arith();
        t_postfix();
        t_reserved();
        t_underflow();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule